// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Decision Unit

This block makes the per-cycle hazard decisions for a five-stage in-order integer pipeline. The stages, in order, are fetch, decode, execute, memory and write-back, and every instruction spends one cycle in each. The block compares the source register numbers held in the decode and execute pipeline registers with the destination register numbers of the instructions further down the pipe. Its outputs are the following:
- two operand bypass selects for the execute-stage ALU;
- a hold for the program counter and the fetch/decode register;
- a bubble insert for the decode/execute register;
- a flush of the fetch/decode register.

Bypassing hands an ALU result to the next dependent instruction straight away, so such a pair runs without a stall. A load followed at once by a consumer of its destination cannot be covered by bypassing. For that case the block holds the consumer in decode for one cycle and sends a bubble into execute.

Branches are resolved in decode, and fetch continues sequentially by default. When a branch is taken, the one wrongly fetched instruction is flushed. The block is purely combinational. Its inputs come from the surrounding pipeline registers, and every output follows its inputs within the same cycle.

Top module: `hzd_pipe_ctrl`

## Requirements
- R1: An execute-stage source (ex_rs1 for operand A, ex_rs2 for operand B) equal to mem_rd, with mem_reg_we high, gives select code 2'b10 (memory-stage result) on the matching select.
- R2: With no memory-stage match, a source equal to wb_rd with wb_reg_we high gives select code 2'b01 (write-back result). Otherwise the code is 2'b00 (register file).
- R3: When both the memory stage and the write-back stage match the same source, the memory stage wins and the code is 2'b10.
- R4: A source of register 0 never causes bypassing or a stall. Its select is 2'b00, and an ex_rd of 0 requests no stall.
- R5: A producer with its write enable low is never a match, whatever its destination number.
- R6: pc_hold, ifid_hold and idex_bubble are all 1 when ex_mem_read and ex_reg_we are high and a nonzero ex_rd equals id_rs1 or id_rs2.
- R7: In every other case pc_hold, ifid_hold and idex_bubble are 0. This covers an ALU producer in execute and a load that has already reached the memory stage.
- R8: ifid_flush is 1 when id_branch_taken is high, and 0 when it is low. A not-taken branch costs nothing.
- R9: When the load-use stall of R6 is raised, ifid_flush is 0 even if id_branch_taken is high, so the branch is held in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of the instruction in decode |
| id_rs2 | input | REG_AW | Second source register of the instruction in decode |
| id_branch_taken | input | 1 | Branch in decode resolved as taken |
| ex_rs1 | input | REG_AW | First source register of the instruction in execute |
| ex_rs2 | input | REG_AW | Second source register of the instruction in execute |
| ex_rd | input | REG_AW | Destination register of the instruction in execute |
| ex_reg_we | input | 1 | Instruction in execute writes a register |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination register of the instruction in the memory stage |
| mem_reg_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | REG_AW | Destination register of the instruction in write-back |
| wb_reg_we | input | 1 | Write-back instruction writes a register |
| fwd_a_sel | output | 2 | Operand A select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b_sel | output | 2 | Operand B select, same encoding |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Zero the control fields loaded into decode/execute |
| ifid_flush | output | 1 | Replace the fetch/decode contents with a no-op |

## Verification
Every result of this block is due in the same cycle as the stimulus that causes it, with zero register stages between input and output. The bench drives each input vector on the falling clock edge and samples all six outputs two nanoseconds later, well before the next rising edge. The sweeps run register numbers 0 to 3 through every source, destination and enable combination. Each expected select, hold and flush value is computed arithmetically from R1 to R9. One extra vector uses the highest register number to exercise the full compare width.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output hzd_pkg::fwd_sel_e sel
);
  import hzd_pkg::*;

  logic src_live;
  logic mem_hit;
  logic wb_hit;

  always_comb begin
    src_live = |src;
    mem_hit  = src_live && mem_we && (mem_rd == src);
    wb_hit   = src_live && wb_we  && (wb_rd  == src);
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  always_comb begin
    a_r4_zero_src_from_rf: assert (src != '0 || sel == FWD_RF)
      else $error("register 0 source was bypassed");
    a_r5_mem_sel_needs_we: assert (sel != FWD_MEM || mem_we)
      else $error("memory-stage select without write enable");
    a_r2_wb_sel_needs_we: assert (sel != FWD_WB || wb_we)
      else $error("write-back select without write enable");
  end

endmodule

// File: rtl/hzd_load_use.sv
module hzd_load_use #(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic [NSRC-1:0][REG_AW-1:0] id_src,
  input  logic [REG_AW-1:0]           ex_rd,
  input  logic                        ex_we,
  input  logic                        ex_load,
  output logic                        stall
);

  logic [NSRC-1:0] src_hit;
  logic            load_live;

  assign load_live = ex_load && ex_we && (|ex_rd);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_hit[g] = (id_src[g] == ex_rd);
  end

  assign stall = load_live && (|src_hit);

  always_comb begin
    a_r7_stall_needs_load: assert (!stall || ex_load)
      else $error("stall raised without a load in execute");
    a_r4_stall_not_on_r0: assert (!stall || ex_rd != '0)
      else $error("stall raised for register 0");
  end

endmodule

// File: rtl/hzd_branch_ctl.sv
module hzd_branch_ctl (
  input  logic taken,
  input  logic stall,
  output logic flush
);

  assign flush = taken && !stall;

  always_comb begin
    a_r8_flush_needs_taken: assert (!flush || taken)
      else $error("flush without a taken branch");
  end

endmodule

// File: rtl/hzd_pipe_ctrl.sv
module hzd_pipe_ctrl #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_branch_taken,
  input  logic [REG_AW-1:0] ex_rs1,
  input  logic [REG_AW-1:0] ex_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_reg_we,
  input  logic              ex_mem_read,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_reg_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_reg_we,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic              ifid_flush
);
  import hzd_pkg::*;

  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_AW-1:0] ex_src;
  logic [NSRC-1:0][REG_AW-1:0] id_src;
  fwd_sel_e                    sel [NSRC];
  logic                        stall;
  logic                        flush;

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;
  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hzd_fwd_sel #(.REG_AW(REG_AW)) u_sel (
      .src    (ex_src[g]),
      .mem_rd (mem_rd),
      .mem_we (mem_reg_we),
      .wb_rd  (wb_rd),
      .wb_we  (wb_reg_we),
      .sel    (sel[g])
    );
  end

  hzd_load_use #(.REG_AW(REG_AW), .NSRC(NSRC)) u_lu (
    .id_src  (id_src),
    .ex_rd   (ex_rd),
    .ex_we   (ex_reg_we),
    .ex_load (ex_mem_read),
    .stall   (stall)
  );

  hzd_branch_ctl u_br (
    .taken (id_branch_taken),
    .stall (stall),
    .flush (flush)
  );

  assign fwd_a_sel   = sel[0];
  assign fwd_b_sel   = sel[1];
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;
  assign ifid_flush  = flush;

  always_comb begin
    a_r9_stall_beats_flush: assert (!(stall && flush))
      else $error("flush raised during a load-use stall");
    a_r3_sel_code_legal: assert (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11)
      else $error("illegal bypass select code");
  end

endmodule

// File: tb/hzd_pipe_ctrl_test.sv
module hzd_pipe_ctrl_test;

  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0;
  logic [AW-1:0] ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic id_branch_taken = 1'b0, ex_reg_we = 1'b0, ex_mem_read = 1'b0;
  logic mem_reg_we = 1'b0, wb_reg_we = 1'b0;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  hzd_pipe_ctrl #(.REG_AW(AW)) uut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_branch_taken(id_branch_taken),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
    .ex_reg_we(ex_reg_we), .ex_mem_read(ex_mem_read),
    .mem_rd(mem_rd), .mem_reg_we(mem_reg_we),
    .wb_rd(wb_rd), .wb_reg_we(wb_reg_we),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(int s, int m, bit mwe, int w, bit wwe);
    if (s != 0 && mwe && m == s) return 2;
    if (s != 0 && wwe && w == s) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(int s, int m, bit mwe, int w, bit wwe);
    if (s == 0) return "R4";
    if (m == s && w == s && mwe && wwe) return "R3";
    if (m == s && mwe) return "R1";
    if (w == s && wwe) return "R2";
    return "R5";
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all inputs zero
    @(negedge clk); #2;
    chk("R4 idle fwd_a", fwd_a_sel, 0);
    chk("R4 idle fwd_b", fwd_b_sel, 0);
    chk("R7 idle hold", pc_hold, 0);
    chk("R8 idle flush", ifid_flush, 0);

    // Bypass sweep over registers 0..3
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        for (int w = 0; w < 4; w++)
          for (int e = 0; e < 4; e++) begin
            int s2;
            bit mwe, wwe;
            s2 = (s + 2) % 4;
            mwe = e[0];
            wwe = e[1];
            @(negedge clk);
            ex_rs1 = AW'(s); ex_rs2 = AW'(s2);
            mem_rd = AW'(m); wb_rd = AW'(w);
            mem_reg_we = mwe; wb_reg_we = wwe;
            #2;
            chk({sel_tag(s, m, mwe, w, wwe), " fwd_a"}, fwd_a_sel,
                exp_sel(s, m, mwe, w, wwe));
            chk({sel_tag(s2, m, mwe, w, wwe), " fwd_b"}, fwd_b_sel,
                exp_sel(s2, m, mwe, w, wwe));
          end

    // Full-width compare on the top register number
    @(negedge clk);
    ex_rs1 = '1; ex_rs2 = AW'(30); mem_rd = '1; mem_reg_we = 1'b1;
    wb_rd = AW'(30); wb_reg_we = 1'b1;
    #2;
    chk("R1 wide fwd_a", fwd_a_sel, 2);
    chk("R2 wide fwd_b", fwd_b_sel, 1);
    mem_reg_we = 1'b0; wb_reg_we = 1'b0;

    // Load-use and branch sweep
    for (int r1 = 0; r1 < 4; r1++)
      for (int r2 = 0; r2 < 4; r2++)
        for (int d = 0; d < 4; d++)
          for (int c = 0; c < 8; c++) begin
            bit ld, we, tk, st, fl;
            ld = c[0]; we = c[1]; tk = c[2];
            st = ld && we && d != 0 && (d == r1 || d == r2);
            fl = tk && !st;
            @(negedge clk);
            id_rs1 = AW'(r1); id_rs2 = AW'(r2); ex_rd = AW'(d);
            ex_mem_read = ld; ex_reg_we = we; id_branch_taken = tk;
            #2;
            chk(st ? "R6 pc_hold" : "R7 pc_hold", pc_hold, st);
            chk(st ? "R6 ifid_hold" : "R7 ifid_hold", ifid_hold, st);
            chk(st ? "R6 idex_bubble" : "R7 idex_bubble", idex_bubble, st);
            chk((tk && st) ? "R9 flush" : "R8 flush", ifid_flush, fl);
          end

    done = 1'b1;
    finish_run();
  end

endmodule